// File: doc/BRIEF.md
# Systolic Mesh Matrix Multiplier

This block multiplies two square matrices of unsigned integers, A and B, on a square grid of N by N multiply-accumulate cells. A single-cycle `start` pulse captures both operand matrices into internal registers and clears every accumulator. Two edge feeders then inject the operands with a skew. Row i of A travels down mesh column i, and column j of B travels right along mesh row j. Each row or column starts one step later than the one before it. Every cell adds the product of the pair it sees to its own accumulator. It then passes the A operand one cell down and the B operand one cell to the right.

Because of the skew, a cell only ever sees matching operand pairs. The product term for C[i][j] that uses index k reaches its cell at a fixed step. The last term reaches the far corner cell at step 3N-2. A step counter in the block tracks this. When the counter reaches that step, `done` is raised and the full result array is held until the next `start`. The caller loads both matrices, pulses `start`, waits for `done`, and then reads `c_mat`.

Top module: `mmesh_matmul`

## Requirements
- R1: While `rst` is sampled high, and in the cycle after it, `done` reads 0 and every entry of `c_mat` reads 0.
- R2: In the cycle after a clock edge that samples `start` high, `done` reads 0 and every entry of `c_mat` reads 0. This holds even if a previous result was on display.
- R3: `done` stays 0 for the first 3N-3 clock edges after the edge that samples `start`. It reads 1 after the (3N-2)-th such edge.
- R4: When `done` is 1, the entry `c_mat[(i*N+j)*AW +: AW]` equals the sum over k of A[i][k]*B[k][j], with unsigned arithmetic. Inputs are packed row-major: A[i][k] is at `a_mat[(i*N+k)*DW +: DW]` and B[k][j] is at `b_mat[(k*N+j)*DW +: DW]`. This holds for identity and all-zero operands among others.
- R5: The operands are those present on `a_mat` and `b_mat` at the edge that samples `start`. Later changes on those inputs have no effect on the result.
- R6: Once `done` is 1, it and `c_mat` stay unchanged until the next `start`, whatever the operand inputs do.
- R7: With zero-based indices, the term A[i][k]*B[k][j] is added at step i+j+k+1. Step s ends on the s-th clock edge after the `start` edge. So after s such edges, entry C[i][j] holds the sum of exactly those terms whose step is at most s.
- R8: A `start` pulse during a computation abandons it. The block then behaves as for a fresh start with the newly captured operands, including the R3 timing.
- R9: The accumulator width AW = 2*DW + ceil(log2 N) holds the all-ones case, N*(2^DW-1)^2, without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse: capture operands, clear results, begin |
| a_mat | input | N*N*DW | Left operand matrix, row-major |
| b_mat | input | N*N*DW | Right operand matrix, row-major |
| done | output | 1 | Result complete and held |
| c_mat | output | N*N*AW | Product matrix, row-major |

## Verification
The timing assertions count edges from the most recent `start`. They assume `start` is a single-cycle pulse, so it is not held across the edge where completion would fall. The bench lowers `start` at the very next falling edge every time. The drain and hold properties assume that the block runs from operands captured at a `start`. The stimulus only changes `a_mat` and `b_mat` between pulses, or deliberately just after one to show they are ignored. The bench compares every partial sum at every step against an arithmetic model. It does this for patterned, identity, zero and all-ones matrices, and for an interrupted run.

// File: rtl/mmesh_pkg.sv
package mmesh_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // Step (1-based) at which the last product reaches the far corner.
    function automatic int last_step(input int n);
        return 3 * n - 2;
    endfunction

    // Step at which element k of feeder lane l is injected at the edge.
    function automatic int feed_step(input int lane, input int k);
        return lane + k + 1;
    endfunction

    // Accumulator width large enough for n full-scale products.
    function automatic int acc_width(input int n, input int dw);
        return 2 * dw + $clog2(n);
    endfunction

    // Step counter width able to hold last_step(n).
    function automatic int step_width(input int n);
        return $clog2(3 * n);
    endfunction

endpackage

// File: rtl/mmesh_ctrl.sv
module mmesh_ctrl #(
    parameter int N  = 4,
    parameter int SW = mmesh_pkg::step_width(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          run,
    output logic [SW-1:0] step,
    output logic          done
);
    import mmesh_pkg::*;

    localparam logic [SW-1:0] LAST = SW'(last_step(N));

    phase_e        phase_q;
    logic [SW-1:0] step_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            step_q  <= '0;
            done_q  <= 1'b0;
        end else if (start) begin
            phase_q <= PH_RUN;
            step_q  <= SW'(1);
            done_q  <= 1'b0;
        end else if (phase_q == PH_RUN) begin
            if (step_q == LAST) begin
                phase_q <= PH_IDLE;
                done_q  <= 1'b1;
            end else begin
                step_q <= step_q + SW'(1);
            end
        end
    end

    assign run  = (phase_q == PH_RUN);
    assign step = step_q;
    assign done = done_q;

endmodule

// File: rtl/mmesh_feeder.sv
module mmesh_feeder #(
    parameter int N  = 4,
    parameter int DW = 8,
    parameter int SW = mmesh_pkg::step_width(N)
) (
    input  logic              run,
    input  logic [SW-1:0]     step,
    input  logic [N*N*DW-1:0] lanes,   // lane l, element k at (l*N+k)*DW
    output logic [N*DW-1:0]   out_val,
    output logic [N-1:0]      out_vld
);
    for (genvar l = 0; l < N; l++) begin : g_lane
        logic [DW-1:0] pick;
        logic          hit;

        always_comb begin
            pick = '0;
            hit  = 1'b0;
            for (int k = 0; k < N; k++) begin
                if (run && step == SW'(mmesh_pkg::feed_step(l, k))) begin
                    pick = lanes[(l*N+k)*DW +: DW];
                    hit  = 1'b1;
                end
            end
        end

        assign out_val[l*DW +: DW] = pick;
        assign out_vld[l]          = hit;
    end

endmodule

// File: rtl/mmesh_cell.sv
module mmesh_cell #(
    parameter int DW = 8,
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [DW-1:0] n_val,
    input  logic          n_vld,
    input  logic [DW-1:0] w_val,
    input  logic          w_vld,
    output logic [DW-1:0] s_val,
    output logic          s_vld,
    output logic [DW-1:0] e_val,
    output logic          e_vld,
    output logic [AW-1:0] acc
);
    localparam int PW = 2 * DW;

    logic [PW-1:0] prod;
    logic [AW-1:0] acc_q;
    logic [DW-1:0] s_val_q, e_val_q;
    logic          s_vld_q, e_vld_q;

    assign prod = {{DW{1'b0}}, n_val} * {{DW{1'b0}}, w_val};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q   <= '0;
            s_val_q <= '0;
            s_vld_q <= 1'b0;
            e_val_q <= '0;
            e_vld_q <= 1'b0;
        end else begin
            if (n_vld && w_vld) begin
                acc_q <= acc_q + AW'(prod);
            end
            s_vld_q <= n_vld;
            s_val_q <= n_vld ? n_val : '0;
            e_vld_q <= w_vld;
            e_val_q <= w_vld ? w_val : '0;
        end
    end

    assign acc   = acc_q;
    assign s_val = s_val_q;
    assign s_vld = s_vld_q;
    assign e_val = e_val_q;
    assign e_vld = e_vld_q;

endmodule

// File: rtl/mmesh_matmul.sv
module mmesh_matmul #(
    parameter int N  = 4,
    parameter int DW = 8,
    parameter int AW = mmesh_pkg::acc_width(N, DW)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [N*N*DW-1:0] a_mat,
    input  logic [N*N*DW-1:0] b_mat,
    output logic              done,
    output logic [N*N*AW-1:0] c_mat
);
    localparam int SW = mmesh_pkg::step_width(N);

    // Captured operands
    logic [N*N*DW-1:0] a_q, b_q, b_lanes;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
        end else if (start) begin
            a_q <= a_mat;
            b_q <= b_mat;
        end
    end

    // B lanes are columns: lane j element k is B[k][j]
    for (genvar j = 0; j < N; j++) begin : g_bl_j
        for (genvar k = 0; k < N; k++) begin : g_bl_k
            assign b_lanes[(j*N+k)*DW +: DW] = b_q[(k*N+j)*DW +: DW];
        end
    end

    // Sequencing
    logic          run;
    logic [SW-1:0] step;

    mmesh_ctrl #(.N(N), .SW(SW)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .run   (run),
        .step  (step),
        .done  (done)
    );

    // Edge feeders: A rows enter the top, B columns enter the left
    logic [N*DW-1:0] top_val, left_val;
    logic [N-1:0]    top_vld, left_vld;

    mmesh_feeder #(.N(N), .DW(DW), .SW(SW)) u_feed_top (
        .run     (run),
        .step    (step),
        .lanes   (a_q),
        .out_val (top_val),
        .out_vld (top_vld)
    );

    mmesh_feeder #(.N(N), .DW(DW), .SW(SW)) u_feed_left (
        .run     (run),
        .step    (step),
        .lanes   (b_lanes),
        .out_val (left_val),
        .out_vld (left_vld)
    );

    // Mesh wiring: vertical links carry A, horizontal links carry B
    logic [DW-1:0] v_val [N+1][N];
    logic          v_vld [N+1][N];
    logic [DW-1:0] h_val [N][N+1];
    logic          h_vld [N][N+1];
    logic [AW-1:0] acc   [N][N];

    for (genvar c = 0; c < N; c++) begin : g_top
        assign v_val[0][c] = top_val[c*DW +: DW];
        assign v_vld[0][c] = top_vld[c];
    end

    for (genvar r = 0; r < N; r++) begin : g_left
        assign h_val[r][0] = left_val[r*DW +: DW];
        assign h_vld[r][0] = left_vld[r];
    end

    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_col
            mmesh_cell #(.DW(DW), .AW(AW)) u_cell (
                .clk   (clk),
                .rst   (rst),
                .clr   (start),
                .n_val (v_val[r][c]),
                .n_vld (v_vld[r][c]),
                .w_val (h_val[r][c]),
                .w_vld (h_vld[r][c]),
                .s_val (v_val[r+1][c]),
                .s_vld (v_vld[r+1][c]),
                .e_val (h_val[r][c+1]),
                .e_vld (h_vld[r][c+1]),
                .acc   (acc[r][c])
            );
            // Mesh column c holds row c of the result; mesh row r its column r
            assign c_mat[(c*N+r)*AW +: AW] = acc[r][c];
        end
    end

    // Operands leaving the far edges of the mesh
    logic [N-1:0]    spill_a_vld, spill_b_vld;
    logic [N*DW-1:0] spill_a_val, spill_b_val;

    for (genvar x = 0; x < N; x++) begin : g_spill
        assign spill_a_vld[x]            = v_vld[N][x];
        assign spill_a_val[x*DW +: DW]   = v_val[N][x];
        assign spill_b_vld[x]            = h_vld[x][N];
        assign spill_b_val[x*DW +: DW]   = h_val[x][N];
    end

endmodule

// File: rtl/mmesh_checker.sv
module mmesh_checker #(
    parameter int N  = 4,
    parameter int DW = 8,
    parameter int AW = mmesh_pkg::acc_width(N, DW)
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              done,
    input logic [N*N*AW-1:0] c_mat,
    input logic [N-1:0]      spill_a_vld,
    input logic [N-1:0]      spill_b_vld,
    input logic [N*DW-1:0]   spill_a_val,
    input logic [N*DW-1:0]   spill_b_val
);
    localparam int L = mmesh_pkg::last_step(N);

    // Edges since the most recent start (1 right after it), saturating
    int   since_q;
    logic started_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q   <= 0;
            started_q <= 1'b0;
        end else if (start) begin
            since_q   <= 1;
            started_q <= 1'b1;
        end else if (since_q < L + 2) begin
            since_q <= since_q + 1;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!done && c_mat == '0));

    assert_start_clear_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> (!done && c_mat == '0));

    assert_done_not_early_R3: assert property (@(posedge clk) disable iff (rst)
        (started_q && since_q <= L) |-> !done);

    assert_done_on_time_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (since_q == L + 1));

    assert_result_held_R6: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(c_mat)));

    assert_mesh_drained_R6: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (spill_a_vld == '0 && spill_b_vld == '0 &&
                              spill_a_val == '0 && spill_b_val == '0));

endmodule

bind mmesh_matmul mmesh_checker #(.N(N), .DW(DW), .AW(AW)) u_mmesh_checker (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .done        (done),
    .c_mat       (c_mat),
    .spill_a_vld (spill_a_vld),
    .spill_b_vld (spill_b_vld),
    .spill_a_val (spill_a_val),
    .spill_b_val (spill_b_val)
);

// File: tb/test_mmesh_matmul.sv
module test_mmesh_matmul;
    localparam int N  = 4;
    localparam int DW = 8;
    localparam int AW = 2 * DW + $clog2(N);
    localparam int L  = 3 * N - 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [N*N*DW-1:0] a_mat = '0;
    logic [N*N*DW-1:0] b_mat = '0;
    logic              done;
    logic [N*N*AW-1:0] c_mat;

    int checks = 0;
    int errors = 0;
    int am [N][N];
    int bm [N][N];

    always #2 clk = ~clk;

    mmesh_matmul #(.N(N), .DW(DW)) i_mmesh_matmul (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .a_mat (a_mat),
        .b_mat (b_mat),
        .done  (done),
        .c_mat (c_mat)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pack();
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                a_mat[(i*N+j)*DW +: DW] = DW'(am[i][j]);
                b_mat[(i*N+j)*DW +: DW] = DW'(bm[i][j]);
            end
    endtask

    // Sum of terms whose meeting step i+j+k+1 is within s steps
    function automatic longint partial(input int i, input int j, input int s);
        longint sum = 0;
        for (int k = 0; k < N; k++)
            if (i + j + k + 1 <= s) sum += longint'(am[i][k]) * longint'(bm[k][j]);
        return sum;
    endfunction

    task automatic check_c(input int s, input string req);
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                longint act = longint'(c_mat[(i*N+j)*AW +: AW]);
                longint exp = partial(i, j, s);
                chk(act == exp, req, $sformatf("C[%0d][%0d] step %0d", i, j, s), act, exp);
            end
    endtask

    task automatic launch();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    // Run to completion; optionally scramble inputs right after start (R5)
    task automatic run_full(input bit partials, input bit scramble, input string req);
        launch();
        if (scramble) begin
            a_mat = ~a_mat;
            b_mat = {b_mat[N*N*DW-2:0], ~b_mat[N*N*DW-1]};
        end
        chk(done == 1'b0, "R2", "done after start", done, 0);
        check_c(0, "R2");
        for (int s = 1; s <= L; s++) begin
            @(negedge clk);
            chk(done == (s == L), "R3", $sformatf("done at step %0d", s), done, (s == L));
            if (s == L) check_c(s, req);
            else if (partials) check_c(s, "R7");
        end
    endtask

    task automatic fill_pattern(input int seed);
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                am[i][j] = (i * 37 + j * 11 + seed * 53 + 7) % 256;
                bm[i][j] = (i * 13 + j * 71 + seed * 29 + 3) % 256;
            end
        pack();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1", "done in reset", done, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R1", "done after reset", done, 0);
        chk(c_mat == '0, "R1", "c_mat after reset", 0, 0);

        // Patterned matrices, every step checked against the skew model
        for (int seed = 0; seed < 3; seed++) begin
            fill_pattern(seed);
            run_full(1'b1, 1'b0, "R4");
        end

        // Identity times patterned
        fill_pattern(5);
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) am[i][j] = (i == j) ? 1 : 0;
        pack();
        run_full(1'b1, 1'b0, "R4");

        // Zero matrix (clears a previously shown nonzero result)
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) bm[i][j] = 0;
        pack();
        run_full(1'b0, 1'b0, "R4");

        // Full-scale operands
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin am[i][j] = 255; bm[i][j] = 255; end
        pack();
        run_full(1'b0, 1'b0, "R9");

        // Inputs changed right after capture
        fill_pattern(7);
        run_full(1'b0, 1'b1, "R5");

        // Result and done held while inputs move
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            a_mat = a_mat + 1;
            b_mat = ~b_mat;
            chk(done == 1'b1, "R6", "done held", done, 1);
        end
        check_c(L, "R6");

        // Restart during a run
        fill_pattern(9);
        launch();
        repeat (4) @(negedge clk);
        fill_pattern(11);
        run_full(1'b1, 1'b0, "R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R3 watchdog: actual no completion expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule